// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This unit runs element-by-element comparisons over one vector register. Each element is checked against the matching element of a second register, or against one broadcast scalar. The result is one boolean per element, kept in an internal mask register. The same mask is then used in two ways. A population-count operation reduces it to a scalar. A masked add or subtract lets only those elements whose mask bit is set reach the register-file write port.

Elements stream one per cycle. The unit presents an element index to a register file whose read data returns one cycle later. It computes the compare or the sum in that cycle and registers the write-port outputs one cycle after that. A start pulse latches the whole command. A done pulse marks the end of the command.

Top module: `vcm_unit`

## Requirements
- R1: In vector-vector mode, compare mask bit i is 1 exactly when element i of source A and element i of source B satisfy the selected relation as signed 64-bit two's-complement values. Relation select: 0 equal, 1 not equal, 2 A greater than B, 3 A less than B, 4 A greater or equal, 5 A less or equal.
- R2: In vector-scalar mode (`scalar_mode_i`=1), every element of A is compared with `scalar_i` instead of with B.
- R3: A compare with effective length L leaves every mask bit at index L or above at 0. L=0 clears the whole mask.
- R4: A population-count command (op 1) sets `popcnt_o` to the number of 1 bits in the mask, with `done_o` high in the cycle after start.
- R5: A masked command with masking enabled asserts `wr_en_o` for element i only when mask bit i is 1. Op 2 writes A+B and op 3 writes A−B, with `scalar_i` standing in for B in vector-scalar mode.
- R6: With masking disabled (`mask_en_i`=0), a masked command writes every element below L.
- R7: Element i is written in the cycle 3+i cycles after the start cycle, in ascending index order. No index at or above L is written. L is `vl_i` clamped to 64.
- R8: For compare and masked commands, `done_o` pulses one cycle after the last element's write slot, that is max(L,1)+3 cycles after the start cycle. `busy_o` is low in that cycle.
- R9: A start while `busy_o` is high is ignored. The running command's writes, mask and timing are unchanged, and no extra command follows.
- R10: After reset, `busy_o`, `done_o` and `wr_en_o` are 0, and the mask and `popcnt_o` are 0.
- R11: Compare and population-count commands never assert `wr_en_o`, and commands other than compare leave the mask unchanged.
- R12: Relation codes 6 and 7 produce 0 for every element below L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start pulse |
| op_i | input | 2 | 0 compare, 1 population count, 2 masked add, 3 masked subtract |
| rel_i | input | 3 | Compare relation code |
| scalar_mode_i | input | 1 | 1 selects the broadcast scalar as second operand |
| mask_en_i | input | 1 | 1 gates masked writes by the mask |
| vl_i | input | 7 | Vector length (values above 64 act as 64) |
| scalar_i | input | 64 | Broadcast scalar operand |
| rd_en_o | output | 1 | Register-file read request |
| rd_idx_o | output | 6 | Element index being read |
| rd_a_i | input | 64 | Source A element, one cycle after the request |
| rd_b_i | input | 64 | Source B element, one cycle after the request |
| wr_en_o | output | 1 | Element write enable |
| wr_idx_o | output | 6 | Element write index |
| wr_data_o | output | 64 | Element write data |
| mask_o | output | 64 | Mask register contents |
| popcnt_o | output | 7 | Population count result |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished pulse |

## Verification
The hardest case to reach is a start request that arrives while a masked command is running, because it can clobber a mask that the same command is still reading. The stimulus fires a compare request with a different length in the second cycle of a masked command. It then checks that every write, the mask and the done cycle match the original command. Signed corner cases, such as the most negative value against the most positive, are hard to hit by chance. The register file is therefore seeded with those extremes and with many A=B pairs, and the scalar is often taken from source A, so that equality and boundary relations occur often.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_POP  = 2'd1,
    OP_MADD = 2'd2,
    OP_MSUB = 2'd3
  } vcm_op_e;

  localparam logic [2:0] REL_EQ = 3'd0;
  localparam logic [2:0] REL_NE = 3'd1;
  localparam logic [2:0] REL_GT = 3'd2;
  localparam logic [2:0] REL_LT = 3'd3;
  localparam logic [2:0] REL_GE = 3'd4;
  localparam logic [2:0] REL_LE = 3'd5;

  typedef struct packed {
    vcm_op_e    op;
    logic [2:0] rel;
    logic       smode;
    logic       men;
  } vcm_cfg_t;
endpackage

// File: rtl/vcm_cmp.sv
module vcm_cmp #(
  parameter int EW = 64
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [2:0]    rel_i,
  output logic          hit_o
);
  import vcm_pkg::*;

  logic signed [EW-1:0] sa, sb;
  assign sa = a_i;
  assign sb = b_i;

  always_comb begin
    case (rel_i)
      REL_EQ:  hit_o = (sa == sb);
      REL_NE:  hit_o = (sa != sb);
      REL_GT:  hit_o = (sa >  sb);
      REL_LT:  hit_o = (sa <  sb);
      REL_GE:  hit_o = (sa >= sb);
      REL_LE:  hit_o = (sa <= sb);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcm_popcount.sv
module vcm_popcount #(
  parameter int W  = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(bits_i[i]);
    end
  end
endmodule

// File: rtl/vcm_seq.sv
module vcm_seq #(
  parameter int NE = 64,
  localparam int IW = $clog2(NE),
  localparam int LW = $clog2(NE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [LW-1:0] vl_i,
  input  logic          drain_done_i,
  output logic          busy_o,
  output logic          iss_vld_o,
  output logic          iss_last_o,
  output logic [IW-1:0] iss_idx_o,
  output logic [LW-1:0] vl_q_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN} seq_state_e;

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [LW-1:0] vl_q, vl_d;
  logic          last;
  logic          adv;

  assign last = (state_q == S_ISSUE) &&
                ((vl_q == '0) || (LW'(idx_q) == vl_q - LW'(1)));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    vl_d    = vl_q;
    case (state_q)
      S_IDLE: begin
        if (go_i) begin
          state_d = S_ISSUE;
          idx_d   = '0;
          vl_d    = vl_i;
        end
      end
      S_ISSUE: begin
        if (last) state_d = S_DRAIN;
        else      idx_d   = idx_q + IW'(1);
      end
      S_DRAIN: begin
        if (drain_done_i) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign adv = (state_q != S_IDLE) || go_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else if (adv) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      vl_q    <= vl_d;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign iss_vld_o  = (state_q == S_ISSUE) && (LW'(idx_q) < vl_q);
  assign iss_last_o = last;
  assign iss_idx_o  = idx_q;
  assign vl_q_o     = vl_q;

  // R7: indices advance by one per cycle while issuing
  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ISSUE && !last) |=> (idx_q == $past(idx_q) + IW'(1)));

  // R9: an issuing command cannot fall back to idle without draining
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ISSUE) |=> (state_q != S_IDLE));
endmodule

// File: rtl/vcm_unit.sv
module vcm_unit #(
  parameter int NE = 64,
  parameter int EW = 64,
  localparam int IW = $clog2(NE),
  localparam int LW = $clog2(NE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [2:0]    rel_i,
  input  logic          scalar_mode_i,
  input  logic          mask_en_i,
  input  logic [LW-1:0] vl_i,
  input  logic [EW-1:0] scalar_i,
  output logic          rd_en_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic [EW-1:0] rd_a_i,
  input  logic [EW-1:0] rd_b_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [EW-1:0] wr_data_o,
  output logic [NE-1:0] mask_o,
  output logic [LW-1:0] popcnt_o,
  output logic          busy_o,
  output logic          done_o
);
  import vcm_pkg::*;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // command acceptance
  logic          busy;
  logic          accept, elem_go, pop_go, cmp_go;
  logic [LW-1:0] vl_eff, vl_q;
  vcm_cfg_t      cfg_q, cfg_d;
  logic [EW-1:0] scl_q, scl_d;

  assign accept  = start_i && !busy;
  assign pop_go  = accept && (vcm_op_e'(op_i) == OP_POP);
  assign elem_go = accept && (vcm_op_e'(op_i) != OP_POP);
  assign cmp_go  = accept && (vcm_op_e'(op_i) == OP_CMP);
  assign vl_eff  = (vl_i > LW'(NE)) ? LW'(NE) : vl_i;

  always_comb begin
    cfg_d = cfg_q;
    scl_d = scl_q;
    if (elem_go) begin
      cfg_d.op    = vcm_op_e'(op_i);
      cfg_d.rel   = rel_i;
      cfg_d.smode = scalar_mode_i;
      cfg_d.men   = mask_en_i;
      scl_d       = scalar_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q <= '0;
      scl_q <= '0;
    end else if (elem_go) begin
      cfg_q <= cfg_d;
      scl_q <= scl_d;
    end
  end

  // element sequencer
  logic          iss_vld, iss_last;
  logic [IW-1:0] iss_idx;
  logic          s2_last_q;

  vcm_seq #(.NE(NE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .go_i         (elem_go),
    .vl_i         (vl_eff),
    .drain_done_i (s2_last_q),
    .busy_o       (busy),
    .iss_vld_o    (iss_vld),
    .iss_last_o   (iss_last),
    .iss_idx_o    (iss_idx),
    .vl_q_o       (vl_q)
  );

  assign rd_en_o  = iss_vld;
  assign rd_idx_o = iss_idx;

  // stage 1: read data arrives
  logic          s1_vld_q, s1_last_q;
  logic [IW-1:0] s1_idx_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_vld_q  <= 1'b0;
      s1_last_q <= 1'b0;
      s1_idx_q  <= '0;
    end else begin
      s1_vld_q  <= iss_vld;
      s1_last_q <= iss_last;
      s1_idx_q  <= iss_idx;
    end
  end

  logic [EW-1:0] opb;
  logic          hit;
  logic [EW-1:0] res;

  assign opb = cfg_q.smode ? scl_q : rd_b_i;

  vcm_cmp #(.EW(EW)) u_cmp (
    .a_i   (rd_a_i),
    .b_i   (opb),
    .rel_i (cfg_q.rel),
    .hit_o (hit)
  );

  assign res = (cfg_q.op == OP_MSUB) ? (rd_a_i - opb) : (rd_a_i + opb);

  // mask register and length masks
  logic [NE-1:0] mask_q, mask_d;
  logic [NE-1:0] low_go, low_q;

  for (genvar g = 0; g < NE; g++) begin : g_low
    assign low_go[g] = (LW'(g) < vl_eff);
    assign low_q[g]  = (LW'(g) < vl_q);
  end

  always_comb begin
    mask_d = mask_q;
    if (cmp_go) begin
      mask_d = mask_q & low_go;
    end else if (s1_vld_q && cfg_q.op == OP_CMP) begin
      mask_d[s1_idx_q] = hit;
    end
  end

  // stage 2: write port, done
  logic          wr_en_d, wr_en_q;
  logic [IW-1:0] wr_idx_q;
  logic [EW-1:0] wr_data_q;
  logic          done_d, done_q;
  logic [LW-1:0] pop_cnt, pop_q;
  logic          masked_op;

  assign masked_op = (cfg_q.op == OP_MADD) || (cfg_q.op == OP_MSUB);
  assign wr_en_d   = s1_vld_q && masked_op && (!cfg_q.men || mask_q[s1_idx_q]);
  assign done_d    = s2_last_q || pop_go;

  vcm_popcount #(.W(NE)) u_pop (
    .bits_i (mask_q),
    .cnt_o  (pop_cnt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      s2_last_q <= 1'b0;
      done_q    <= 1'b0;
      pop_q     <= '0;
    end else begin
      mask_q    <= mask_d;
      wr_en_q   <= wr_en_d;
      s2_last_q <= s1_last_q;
      done_q    <= done_d;
      if (s1_vld_q) begin
        wr_idx_q  <= s1_idx_q;
        wr_data_q <= res;
      end
      if (pop_go) pop_q <= pop_cnt;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign mask_o    = mask_q;
  assign popcnt_o  = pop_q;
  assign busy_o    = busy;
  assign done_o    = done_q;

  // R7: writes stay below the latched length
  p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en_q |-> (LW'(wr_idx_q) < vl_q));

  // R5: with masking on, a write only lands on a set mask bit
  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en_q && cfg_q.men) |-> mask_q[wr_idx_q]);

  // R11: a running compare never writes the register file
  p_cmp_silent_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && cfg_q.op == OP_CMP) |-> !wr_en_q);

  // R3: during a compare, bits at or above the length stay clear
  p_high_clear_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && cfg_q.op == OP_CMP) |-> ((mask_q & ~low_q) == '0));

  // R8: completion coincides with the unit being free
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_q |-> !busy);

  // R4: the count never exceeds the mask width
  p_pop_range_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pop_q <= LW'(NE)));
endmodule

// File: tb/vcm_unit_test.sv
`timescale 1ns/1ps
module vcm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [2:0]  rel;
  logic        smode, men;
  logic [6:0]  vl;
  logic [63:0] scalar;
  logic        rd_en;
  logic [5:0]  rd_idx;
  logic [63:0] rd_a, rd_b;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic [63:0] mask;
  logic [6:0]  popcnt;
  logic        busy, done;

  logic [63:0] va [64];
  logic [63:0] vb [64];
  logic [63:0] emask;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vcm_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .rel_i(rel),
    .scalar_mode_i(smode), .mask_en_i(men), .vl_i(vl), .scalar_i(scalar),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .rd_a_i(rd_a), .rd_b_i(rd_b),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .mask_o(mask), .popcnt_o(popcnt), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    rd_a <= va[rd_idx];
    rd_b <= vb[rd_idx];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit relf(input logic signed [63:0] a, input logic signed [63:0] b,
                              input logic [2:0] r);
    case (r)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return a > b;
      3'd3: return a < b;
      3'd4: return a >= b;
      3'd5: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int ones(input logic [63:0] m);
    int c = 0;
    for (int i = 0; i < 64; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [63:0] corner(input int sel);
    case (sel)
      0: return 64'h8000_0000_0000_0000;
      1: return 64'h7fff_ffff_ffff_ffff;
      2: return 64'h0;
      default: return 64'hffff_ffff_ffff_ffff;
    endcase
  endfunction

  task automatic fill_rf();
    for (int i = 0; i < 64; i++) begin
      if ($urandom % 5 == 0) va[i] = corner($urandom % 4);
      else va[i] = {$urandom, $urandom};
      case ($urandom % 4)
        0: vb[i] = va[i];
        1: vb[i] = corner($urandom % 4);
        default: vb[i] = {$urandom, $urandom};
      endcase
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [2:0] r, input logic sm,
                        input logic me, input logic [6:0] l, input logic [63:0] s,
                        input bit poke);
    int n, ne, exp_done, got_done, wp, nexp;
    int exp_idx [64];
    logic [63:0] exp_dat [64];
    logic [63:0] new_mask;
    bit wrote_bad;
    n  = (l > 7'd64) ? 64 : int'(l);
    ne = (n == 0) ? 1 : n;
    exp_done = (o == 2'd1) ? 1 : ne + 3;
    nexp = 0;
    if (o[1]) begin
      for (int i = 0; i < n; i++) begin
        logic [63:0] b;
        b = sm ? s : vb[i];
        if (!me || emask[i]) begin
          exp_idx[nexp] = i;
          exp_dat[nexp] = (o == 2'd3) ? va[i] - b : va[i] + b;
          nexp++;
        end
      end
    end
    new_mask = emask;
    if (o == 2'd0) begin
      new_mask = '0;
      for (int i = 0; i < n; i++) new_mask[i] = relf(va[i], sm ? s : vb[i], r);
    end

    start = 1'b1; op = o; rel = r; smode = sm; men = me; vl = l; scalar = s;
    @(negedge clk);
    start = 1'b0; op = $urandom; rel = $urandom; smode = $urandom;
    men = $urandom; vl = $urandom; scalar = {$urandom, $urandom};
    got_done = -1; wp = 0; wrote_bad = 0;
    for (int k = 1; k <= 200; k++) begin
      if (wr_en) begin
        if (wp >= nexp) wrote_bad = 1;
        else begin
          chk(int'(wr_idx) == exp_idx[wp], me ? "R5" : "R6", "write index",
              64'(wr_idx), 64'(exp_idx[wp]));
          chk(wr_data == exp_dat[wp], me ? "R5" : "R6", "write data",
              wr_data, exp_dat[wp]);
          chk(k == 3 + exp_idx[wp], "R7", "write cycle", 64'(k), 64'(3 + exp_idx[wp]));
        end
        wp++;
      end
      if (done) begin
        got_done = k;
        chk(!busy, "R8", "busy at done", 64'(busy), 64'd0);
        break;
      end
      if (poke && k == 2) begin
        start = 1'b1; op = 2'd0; rel = 3'd1; vl = 7'd5; smode = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(got_done == exp_done, poke ? "R9" : "R8", "done cycle",
        64'(got_done), 64'(exp_done));
    if (o[1]) chk(wp == nexp, me ? "R5" : "R6", "write count", 64'(wp), 64'(nexp));
    else chk(!wrote_bad && wp == 0, "R11", "writes during non-write op", 64'(wp), 64'd0);
    if (o == 2'd0) begin
      logic [63:0] lowm;
      lowm = '0;
      for (int i = 0; i < n; i++) lowm[i] = 1'b1;
      if (r > 3'd5) chk(mask == 64'd0, "R12", "unused relation mask", mask, 64'd0);
      else chk((mask & lowm) == (new_mask & lowm), sm ? "R2" : "R1", "compare mask",
               mask & lowm, new_mask & lowm);
      chk((mask & ~lowm) == 64'd0, "R3", "mask above length", mask & ~lowm, 64'd0);
    end else begin
      chk(mask == emask, poke ? "R9" : "R11", "mask kept", mask, emask);
    end
    if (o == 2'd1)
      chk(int'(popcnt) == ones(emask), "R4", "population count", 64'(popcnt), 64'(ones(emask)));
    emask = new_mask;
    @(negedge clk);
    if (poke) chk(!busy && !done, "R9", "no extra command", {busy, done}, 64'd0);
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    start = 0; op = 0; rel = 0; smode = 0; men = 0; vl = 0; scalar = 0;
    emask = '0;
    for (int i = 0; i < 64; i++) begin va[i] = '0; vb[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk({busy, done, wr_en} == 3'b000, "R10", "control after reset", {busy, done, wr_en}, 64'd0);
    chk(mask == 64'd0, "R10", "mask after reset", mask, 64'd0);
    chk(popcnt == 7'd0, "R10", "count after reset", 64'(popcnt), 64'd0);

    fill_rf();
    run_op(2'd0, 3'd0, 1'b0, 1'b0, 7'd64, 64'd0, 0);      // R1 equality
    run_op(2'd1, 3'd0, 1'b0, 1'b0, 7'd0, 64'd0, 0);       // R4
    run_op(2'd2, 3'd0, 1'b0, 1'b1, 7'd64, 64'd0, 0);      // R5
    run_op(2'd3, 3'd0, 1'b1, 1'b0, 7'd40, 64'd17, 0);     // R6
    run_op(2'd0, 3'd2, 1'b1, 1'b0, 7'd64, va[7], 0);      // R2
    run_op(2'd0, 3'd3, 1'b0, 1'b0, 7'd10, 64'd0, 0);      // R3 shorter length
    run_op(2'd1, 3'd0, 1'b0, 1'b0, 7'd0, 64'd0, 0);
    run_op(2'd0, 3'd5, 1'b0, 1'b0, 7'd64, 64'd0, 0);
    run_op(2'd2, 3'd0, 1'b0, 1'b1, 7'd20, 64'd0, 1);      // R9 poke
    run_op(2'd0, 3'd4, 1'b0, 1'b0, 7'd0, 64'd0, 0);       // R3 length zero
    run_op(2'd1, 3'd0, 1'b0, 1'b0, 7'd0, 64'd0, 0);
    run_op(2'd0, 3'd1, 1'b0, 1'b0, 7'd100, 64'd0, 0);     // R7 clamp
    run_op(2'd0, 3'd6, 1'b0, 1'b0, 7'd64, 64'd0, 0);      // R12
    run_op(2'd0, 3'd1, 1'b0, 1'b0, 7'd1, 64'd0, 0);
    run_op(2'd3, 3'd0, 1'b0, 1'b1, 7'd1, 64'd0, 0);
    for (int t = 0; t < 50; t++) begin
      logic [1:0] ro;
      logic [6:0] rl;
      if (t % 10 == 0) fill_rf();
      ro = $urandom;
      rl = ($urandom % 4 == 0) ? 7'($urandom % 3) : 7'($urandom % 70);
      run_op(ro, 3'($urandom), 1'($urandom), 1'($urandom), rl,
             ($urandom % 2) ? va[$urandom % 64] : {$urandom, $urandom}, ($urandom % 6 == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule